// File: doc/BRIEF.md
# Prioritized Interrupt Entry and Return Sequencer

This block is the control sequencer a small 16-bit processor uses to take device interrupts and to come back from them. When the core signals that an instruction has finished, the sequencer compares the level of an enabled, requesting device with the level held in the running program's status word. It accepts the request only if the device level is strictly higher. It then walks a fixed entry sequence. If the program was in user mode, the stack pointer is swapped to the supervisor stack. The old status word and the old PC are pushed. The handler address is read from a vector table, and the core is handed a new PC, status word and stack pointer in one load strobe.

The reverse sequence starts on a return request from the core. It pops the PC and then the status word from the current stack. If the restored status word is in user mode, the live stack pointer is parked as the supervisor stack pointer and the saved user stack pointer is handed back. Both saved stack pointers are held inside the block. All memory traffic goes through one single-port word interface. Reads are combinational within the cycle and writes land on the clock edge, so each access costs one cycle.

Status word layout used throughout: bit 15 is the mode bit (1 = user, 0 = privileged), bits 10:8 hold the priority level, and bits 2:0 are the N, Z and P condition codes.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted on a rising clock edge only when the sequencer is idle and not driving its load strobe, `insn_done`, `dev_ie` and `dev_req` are all 1, `rti_req` is 0, and `dev_lvl` is strictly greater than `cur_psr[10:8]`.
- R2: A request whose level is equal to or below `cur_psr[10:8]`, or whose enable or instruction-boundary input is 0, causes no memory write, no busy and no load strobe.
- R3: On entry from user mode (`cur_psr[15]`=1), `cur_r6` is saved as the user stack pointer and the saved supervisor stack pointer S is used. The status word is written at S-1, the PC at S-2, and `nxt_r6` = S-2.
- R4: On entry from privileged mode (`cur_psr[15]`=0), there is no swap and the saved user stack pointer is untouched. The status word is written at `cur_r6`-1, the PC at `cur_r6`-2, and `nxt_r6` = `cur_r6`-2.
- R5: On entry, `nxt_psr` equals `cur_psr` with bit 15 cleared, bits 2:0 cleared, and bits 10:8 replaced by `dev_lvl`. All other bits are kept.
- R6: On entry, `nxt_pc` is the word read at address `VEC_BASE` + `dev_vec` (0x0100 to 0x01FF with the default base).
- R7: Entry keeps `busy` high for exactly 3 cycles after the accepting edge. Return keeps it high for 2 cycles. `nxt_load` pulses for one cycle as `busy` falls. The memory interface is enabled only while `busy` is high.
- R8: On return, the PC is read at `cur_r6` and the status word at `cur_r6`+1, with no memory write. `nxt_pc` and `nxt_psr` are the popped words.
- R9: On return to user mode (popped bit 15 = 1), `cur_r6`+2 becomes the saved supervisor stack pointer and `nxt_r6` is the saved user stack pointer. On return to privileged mode, `nxt_r6` = `cur_r6`+2.
- R10: `rti_req` takes precedence over a simultaneously acceptable interrupt request.
- R11: After reset, `busy`, `nxt_load` and `mem_en` are 0, and the saved supervisor stack pointer equals `SSP_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | 1 | Device is requesting service |
| dev_ie | input | 1 | Device interrupt-enable bit |
| dev_lvl | input | 3 | Requesting device priority level |
| dev_vec | input | 8 | Device vector, index into the vector table |
| insn_done | input | 1 | Core has completed the current instruction |
| rti_req | input | 1 | Core requests a return from interrupt |
| cur_pc | input | 16 | Current program counter |
| cur_psr | input | 16 | Current status word |
| cur_r6 | input | 16 | Current stack pointer register |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the same cycle |
| nxt_pc | output | 16 | PC for the core to load |
| nxt_psr | output | 16 | Status word for the core to load |
| nxt_r6 | output | 16 | Stack pointer for the core to load |
| nxt_load | output | 1 | One-cycle strobe: the three values above are valid |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with `SSP_RESET` = 0x0300 and keeps `VEC_BASE` at 0x0100. This lets one 1024-word model memory hold both the whole vector table and the supervisor stack without aliasing. It also lets the first user-mode entry show the reset value of the supervisor pointer directly through the address of the first push. With these values, the bench can reach a nested privileged entry on top of a user entry, then both unwinding returns, and then a fresh user entry. That last entry proves the supervisor pointer was restored. It also reaches the last vector slot 0xFF and the level-0 and level-7 extremes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int WORD_W   = 16;
    localparam int LVL_W    = 3;
    localparam int VEC_W    = 8;
    localparam int MODE_BIT = 15;
    localparam int LVL_LSB  = 8;
    localparam int CC_W     = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PSR,
        ST_PUSH_PC,
        ST_VEC_RD,
        ST_POP_PC,
        ST_POP_PSR
    } seq_state_e;

    // Context captured when a sequence starts.
    typedef struct packed {
        word_t pc;
        word_t psr;
        word_t sp;
        vec_t  vec;
        lvl_t  lvl;
    } frame_t;

    function automatic lvl_t psr_level(input word_t p);
        return p[LVL_LSB +: LVL_W];
    endfunction

    function automatic logic psr_is_user(input word_t p);
        return p[MODE_BIT];
    endfunction

    // Status word handed to the handler: privileged, new level, codes cleared.
    function automatic word_t entry_psr(input word_t p, input lvl_t l);
        word_t r;
        r = p;
        r[MODE_BIT] = 1'b0;
        r[LVL_LSB +: LVL_W] = l;
        r[CC_W-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_seq_pkg::*;
(
    input  logic  idle,
    input  logic  insn_done,
    input  logic  dev_req,
    input  logic  dev_ie,
    input  lvl_t  dev_lvl,
    input  word_t cur_psr,
    output logic  take
);
    logic outranks;

    always_comb begin
        outranks = dev_lvl > psr_level(cur_psr);
        take     = idle && insn_done && dev_req && dev_ie && outranks;
    end
endmodule

// File: rtl/sp_bank.sv
module sp_bank
    import irq_seq_pkg::*;
#(
    parameter word_t SSP_RESET = 16'h3000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  save_usp,
    input  word_t usp_in,
    input  logic  save_ssp,
    input  word_t ssp_in,
    output word_t usp,
    output word_t ssp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            usp <= '0;
            ssp <= SSP_RESET;
        end else begin
            if (save_usp) usp <= usp_in;
            if (save_ssp) ssp <= ssp_in;
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter word_t VEC_BASE  = 16'h0100,
    parameter word_t SSP_RESET = 16'h3000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dev_req,
    input  logic        dev_ie,
    input  logic [2:0]  dev_lvl,
    input  logic [7:0]  dev_vec,
    input  logic        insn_done,
    input  logic        rti_req,
    input  logic [15:0] cur_pc,
    input  logic [15:0] cur_psr,
    input  logic [15:0] cur_r6,
    output logic        mem_en,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic [15:0] nxt_pc,
    output logic [15:0] nxt_psr,
    output logic [15:0] nxt_r6,
    output logic        nxt_load,
    output logic        busy
);
    localparam word_t ONE = word_t'(1);

    seq_state_e state_q;
    frame_t     fr_q;
    logic       entry_q;

    logic  idle;
    logic  irq_ok;
    logic  go_rti;
    logic  go_irq;
    word_t usp;
    word_t ssp;
    word_t sp_start;
    word_t sp_down;
    word_t sp_up;
    logic  ret_user;

    assign idle     = (state_q == ST_IDLE) && !nxt_load;
    assign go_rti   = idle && rti_req;
    assign go_irq   = irq_ok && !rti_req;
    assign sp_start = psr_is_user(cur_psr) ? ssp : cur_r6;
    assign sp_down  = fr_q.sp - ONE;
    assign sp_up    = fr_q.sp + ONE;
    assign ret_user = (state_q == ST_POP_PSR) && psr_is_user(mem_rdata);
    assign busy     = (state_q != ST_IDLE);

    irq_gate u_gate (
        .idle      (idle),
        .insn_done (insn_done),
        .dev_req   (dev_req),
        .dev_ie    (dev_ie),
        .dev_lvl   (dev_lvl),
        .cur_psr   (cur_psr),
        .take      (irq_ok)
    );

    sp_bank #(.SSP_RESET(SSP_RESET)) u_sp (
        .clk      (clk),
        .rst      (rst),
        .save_usp (go_irq && psr_is_user(cur_psr)),
        .usp_in   (cur_r6),
        .save_ssp (ret_user),
        .ssp_in   (sp_up),
        .usp      (usp),
        .ssp      (ssp)
    );

    // Memory port: driven from the current step only.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_PUSH_PSR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_down;
                mem_wdata = fr_q.psr;
            end
            ST_PUSH_PC: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_down;
                mem_wdata = fr_q.pc;
            end
            ST_VEC_RD: begin
                mem_en   = 1'b1;
                mem_addr = VEC_BASE + {{(WORD_W-VEC_W){1'b0}}, fr_q.vec};
            end
            ST_POP_PC, ST_POP_PSR: begin
                mem_en   = 1'b1;
                mem_addr = fr_q.sp;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            fr_q     <= '0;
            entry_q  <= 1'b0;
            nxt_pc   <= '0;
            nxt_psr  <= '0;
            nxt_r6   <= '0;
            nxt_load <= 1'b0;
        end else begin
            nxt_load <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (go_rti) begin
                        fr_q.sp <= cur_r6;
                        entry_q <= 1'b0;
                        state_q <= ST_POP_PC;
                    end else if (go_irq) begin
                        fr_q.pc  <= cur_pc;
                        fr_q.psr <= cur_psr;
                        fr_q.sp  <= sp_start;
                        fr_q.vec <= dev_vec;
                        fr_q.lvl <= dev_lvl;
                        entry_q  <= 1'b1;
                        state_q  <= ST_PUSH_PSR;
                    end
                end
                ST_PUSH_PSR: begin
                    fr_q.sp <= sp_down;
                    state_q <= ST_PUSH_PC;
                end
                ST_PUSH_PC: begin
                    fr_q.sp <= sp_down;
                    state_q <= ST_VEC_RD;
                end
                ST_VEC_RD: begin
                    nxt_pc   <= mem_rdata;
                    nxt_psr  <= entry_psr(fr_q.psr, fr_q.lvl);
                    nxt_r6   <= fr_q.sp;
                    nxt_load <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                ST_POP_PC: begin
                    fr_q.pc <= mem_rdata;
                    fr_q.sp <= sp_up;
                    state_q <= ST_POP_PSR;
                end
                ST_POP_PSR: begin
                    nxt_pc   <= fr_q.pc;
                    nxt_psr  <= mem_rdata;
                    nxt_r6   <= ret_user ? usp : sp_up;
                    nxt_load <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        nxt_load,
    input logic        mem_en,
    input logic        mem_we,
    input logic        dev_req,
    input logic        dev_ie,
    input logic [2:0]  dev_lvl,
    input logic        insn_done,
    input logic        rti_req,
    input logic [15:0] cur_psr,
    input logic [15:0] nxt_psr,
    input logic        entry_q
);
    // R7
    mem_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> busy);

    // R7
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        nxt_load |=> !nxt_load);

    // R7
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        nxt_load |-> !busy);

    // R1
    accept_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(rti_req) ||
            ($past(dev_req) && $past(dev_ie) && $past(insn_done) &&
             ($past(dev_lvl) > $past(cur_psr[10:8])))));

    // R5
    entry_psr_chk: assert property (@(posedge clk) disable iff (rst)
        (nxt_load && entry_q) |-> (!nxt_psr[15] && (nxt_psr[2:0] == 3'b000)));

    // R8
    return_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !entry_q) |-> !mem_we);
endmodule

bind irq_entry_seq irq_seq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .nxt_load  (nxt_load),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .dev_req   (dev_req),
    .dev_ie    (dev_ie),
    .dev_lvl   (dev_lvl),
    .insn_done (insn_done),
    .rti_req   (rti_req),
    .cur_psr   (cur_psr),
    .nxt_psr   (nxt_psr),
    .entry_q   (entry_q)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dev_req = 1'b0;
    logic        dev_ie = 1'b0;
    logic [2:0]  dev_lvl = '0;
    logic [7:0]  dev_vec = '0;
    logic        insn_done = 1'b0;
    logic        rti_req = 1'b0;
    logic [15:0] cur_pc = '0;
    logic [15:0] cur_psr = '0;
    logic [15:0] cur_r6 = '0;
    logic        mem_en;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [15:0] nxt_pc;
    logic [15:0] nxt_psr;
    logic [15:0] nxt_r6;
    logic        nxt_load;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    bit done = 1'b0;

    logic [15:0] tb_mem [1024];

    always #HALF clk = ~clk;

    assign mem_rdata = tb_mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            tb_mem[mem_addr[9:0]] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    irq_entry_seq #(.VEC_BASE(16'h0100), .SSP_RESET(16'h0300)) i_irq_entry_seq (
        .clk(clk), .rst(rst),
        .dev_req(dev_req), .dev_ie(dev_ie), .dev_lvl(dev_lvl), .dev_vec(dev_vec),
        .insn_done(insn_done), .rti_req(rti_req),
        .cur_pc(cur_pc), .cur_psr(cur_psr), .cur_r6(cur_r6),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .nxt_pc(nxt_pc), .nxt_psr(nxt_psr), .nxt_r6(nxt_r6),
        .nxt_load(nxt_load), .busy(busy)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present one request for one accepting edge, then wait for the load strobe.
    // lat: negedges after the accepting edge until nxt_load (-1 if none);
    // bcnt: negedges with busy high before the strobe.
    task automatic launch(input logic irq, input logic ie, input logic dn,
                          input logic rti, input logic [2:0] lvl,
                          input logic [7:0] vec, input logic [15:0] psr,
                          input logic [15:0] r6, input logic [15:0] pc,
                          output int lat, output int bcnt, output int wrs);
        int w0;
        @(negedge clk);
        w0 = wr_cnt;
        dev_req = irq; dev_ie = ie; dev_lvl = lvl; dev_vec = vec;
        rti_req = rti; insn_done = dn;
        cur_psr = psr; cur_r6 = r6; cur_pc = pc;
        @(negedge clk);
        dev_req = 1'b0; rti_req = 1'b0; insn_done = 1'b0;
        lat = -1;
        bcnt = 0;
        for (int n = 0; n < 8; n++) begin
            if (nxt_load) begin
                lat = n;
                break;
            end
            if (busy) bcnt++;
            @(negedge clk);
        end
        wrs = wr_cnt - w0;
    endtask

    task automatic t_reset;
        check("R11", "busy after reset", {15'd0, busy}, 16'd0);
        check("R11", "load after reset", {15'd0, nxt_load}, 16'd0);
        check("R11", "mem_en after reset", {15'd0, mem_en}, 16'd0);
    endtask

    task automatic t_user_entry;
        int lat, bc, w;
        launch(1, 1, 1, 0, 3'd4, 8'h20, 16'h9205, 16'h0380, 16'h3456, lat, bc, w);
        check("R7", "entry latency", 16'(lat), 16'd3);
        check("R7", "entry busy cycles", 16'(bc), 16'd3);
        check("R3", "entry writes", 16'(w), 16'd2);
        check("R3", "psr pushed at ssp-1", tb_mem[10'h2FF], 16'h9205);
        check("R3", "pc pushed at ssp-2", tb_mem[10'h2FE], 16'h3456);
        check("R3", "new r6 on supervisor stack", nxt_r6, 16'h02FE);
        check("R11", "ssp reset value used", nxt_r6 + 16'd2, 16'h0300);
        check("R6", "handler pc", nxt_pc, 16'h4000);
        check("R5", "handler psr", nxt_psr, 16'h1400);
    endtask

    task automatic t_ignored;
        int lat, bc, w;
        launch(1, 1, 1, 0, 3'd4, 8'h21, 16'h1400, 16'h02FE, 16'h4010, lat, bc, w);
        check("R2", "equal level no load", 16'(lat), 16'hFFFF);
        check("R2", "equal level no busy", 16'(bc), 16'd0);
        check("R2", "equal level no write", 16'(w), 16'd0);
        launch(1, 0, 1, 0, 3'd6, 8'h21, 16'h1400, 16'h02FE, 16'h4010, lat, bc, w);
        check("R2", "disabled device no load", 16'(lat), 16'hFFFF);
        check("R2", "disabled device no write", 16'(w), 16'd0);
        launch(1, 1, 0, 0, 3'd6, 8'h21, 16'h1400, 16'h02FE, 16'h4010, lat, bc, w);
        check("R1", "mid-instruction no load", 16'(lat), 16'hFFFF);
        check("R1", "mid-instruction no write", 16'(w), 16'd0);
        launch(1, 1, 1, 0, 3'd0, 8'h22, 16'h8000, 16'h0370, 16'h3000, lat, bc, w);
        check("R2", "level zero never taken", 16'(lat), 16'hFFFF);
    endtask

    task automatic t_nested;
        int lat, bc, w;
        launch(1, 1, 1, 0, 3'd6, 8'h21, 16'h1400, 16'h02FE, 16'h4010, lat, bc, w);
        check("R1", "higher level taken", 16'(lat), 16'd3);
        check("R4", "psr pushed at r6-1", tb_mem[10'h2FD], 16'h1400);
        check("R4", "pc pushed at r6-2", tb_mem[10'h2FC], 16'h4010);
        check("R4", "new r6 without swap", nxt_r6, 16'h02FC);
        check("R6", "nested handler pc", nxt_pc, 16'h5000);
        check("R5", "nested psr level", nxt_psr, 16'h1600);
    endtask

    task automatic t_rti_priv;
        int lat, bc, w;
        launch(0, 0, 0, 1, 3'd0, 8'h00, 16'h1600, 16'h02FC, 16'h5008, lat, bc, w);
        check("R7", "return latency", 16'(lat), 16'd2);
        check("R8", "return writes", 16'(w), 16'd0);
        check("R8", "popped pc", nxt_pc, 16'h4010);
        check("R8", "popped psr", nxt_psr, 16'h1400);
        check("R9", "privileged return r6", nxt_r6, 16'h02FE);
    endtask

    task automatic t_rti_user;
        int lat, bc, w;
        launch(0, 0, 0, 1, 3'd0, 8'h00, 16'h1400, 16'h02FE, 16'h4020, lat, bc, w);
        check("R8", "user return pc", nxt_pc, 16'h3456);
        check("R8", "user return psr", nxt_psr, 16'h9205);
        check("R9", "user stack pointer restored", nxt_r6, 16'h0380);
    endtask

    task automatic t_ssp_restored;
        int lat, bc, w;
        launch(1, 1, 1, 0, 3'd7, 8'hFF, 16'h8000, 16'h0390, 16'h3500, lat, bc, w);
        check("R9", "ssp saved on return", tb_mem[10'h2FF], 16'h8000);
        check("R3", "second user entry r6", nxt_r6, 16'h02FE);
        check("R6", "last vector slot", nxt_pc, 16'h6A6A);
        check("R5", "level seven psr", nxt_psr, 16'h0700);
    endtask

    task automatic t_rti_precedence;
        int lat, bc, w;
        launch(1, 1, 1, 1, 3'd7, 8'h20, 16'h0100, 16'h02FE, 16'h6A70, lat, bc, w);
        check("R10", "return wins latency", 16'(lat), 16'd2);
        check("R10", "return wins no write", 16'(w), 16'd0);
        check("R10", "return wins pc", nxt_pc, 16'h3500);
        check("R10", "return wins r6", nxt_r6, 16'h0390);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) tb_mem[i] = '0;
        tb_mem[10'h120] = 16'h4000;
        tb_mem[10'h121] = 16'h5000;
        tb_mem[10'h1FF] = 16'h6A6A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_user_entry();
        t_ignored();
        t_nested();
        t_rti_priv();
        t_rti_user();
        t_ssp_restored();
        t_rti_precedence();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        #(2 * HALF * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule